// File: doc/BRIEF.md
# I2C Hot-Insertion Connection Controller

This block decides when a card-side I2C segment may be joined to a backplane segment that is already carrying traffic. It is meant for hot insertion and power-up. A power-good input stands in for undervoltage lockout. The block also takes the sampled SDA and SCL levels from both segments: the live (backplane) side and the card side. Its output is a connect-enable that drives an external pass-switch model, and a READY flag that follows it.

After lockout ends, the block assumes the live segment may be in the middle of a transfer. It joins the card only at a safe point on the live side:

- a STOP condition, where SDA rises while SCL is high, or
- a bus-idle interval, where both live lines stay high for `IDLE_CYCLES` clocks.

In either case, both card-side lines must also be high at that moment. The fault logic can ask for a disconnect at any time. After a disconnect, the block joins again only when a new safe point is seen. All four line samples pass through synchronisers before any edge or level is judged.

Top module: `i2c_hot_join_ctrl`

## Requirements
- R1: While `pwr_good` is low, `connect_en` and `ready` are low. Line activity seen during that time, whether a STOP or a long high period, does not count toward a later join.
- R2: A join needs a STOP on the live side or a completed idle interval. A STOP means the synchronised `sda_in` rises while the synchronised `scl_in` is high. If SDA rises while SCL is low, that is not a STOP.
- R3: A join happens only on a cycle where the synchronised `sda_out` and `scl_out` are both high. A STOP that arrives while the card side is held low does not join.
- R4: `connect_en` and `ready` rise on the same clock and are equal on every cycle.
- R5: Idle means the synchronised `sda_in` and `scl_in` have both been high for `IDLE_CYCLES` consecutive cycles. A low on either line restarts the count from zero.
- R6: A high `disc_req` clears `connect_en` by the next clock. While `disc_req` stays high, no join takes place.
- R7: After a disconnect, a join needs a new STOP or a full idle interval. A STOP that was passed over earlier is not remembered.
- R8: A low `pwr_good` returns the block to lockout by the next clock, from any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwr_good | input | 1 | Supply above lockout threshold |
| sda_in | input | 1 | Live-side SDA level |
| scl_in | input | 1 | Live-side SCL level |
| sda_out | input | 1 | Card-side SDA level |
| scl_out | input | 1 | Card-side SCL level |
| disc_req | input | 1 | Disconnect request from the fault logic |
| connect_en | output | 1 | Closes the external pass switch |
| ready | output | 1 | Segments joined |

## Verification
The hardest case to reach is a STOP that is valid in itself but arrives while the card side is held low. The block must pass it over. Once the card releases, it must wait for a completely new idle interval, and it must not join on the stale edge. The bench gets there in steps:

1. It disconnects a joined link.
2. It pulls the card SDA low.
3. It creates a START and then a STOP on the live side.
4. It releases the card side.

It then checks that the link stays open until the idle window has fully elapsed again. A second hard case is traffic on SCL whose high periods are each shorter than the idle window. The bench drives SCL in bursts that are just short of that length and checks that no join slips through.

// File: rtl/hj_pkg.sv
package hj_pkg;
   typedef enum logic [1:0] {
      ST_LOCKOUT = 2'd0,
      ST_WAIT    = 2'd1,
      ST_JOINED  = 2'd2
   } join_state_e;

   localparam int unsigned NUM_LINES = 4;
   localparam int unsigned L_SDAI = 0;
   localparam int unsigned L_SCLI = 1;
   localparam int unsigned L_SDAO = 2;
   localparam int unsigned L_SCLO = 3;
endpackage

// File: rtl/hj_bit_sync.sv
module hj_bit_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/hj_live_watch.sv
module hj_live_watch #(
   parameter int unsigned IDLE_CYCLES = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic sda,
   input  logic scl,
   output logic stop_seen,
   output logic idle_seen
);
   localparam int unsigned CW = $clog2(IDLE_CYCLES + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(IDLE_CYCLES);

   logic          sda_prev_q;
   logic [CW-1:0] idle_cnt_q;
   logic          both_high;

   assign both_high = sda & scl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sda_prev_q <= 1'b1;
      else        sda_prev_q <= sda;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               idle_cnt_q <= '0;
      else if (!arm)            idle_cnt_q <= '0;
      else if (!both_high)      idle_cnt_q <= '0;
      else if (idle_cnt_q != CNT_MAX) idle_cnt_q <= idle_cnt_q + 1'b1;
   end

   assign stop_seen = arm & scl & sda & ~sda_prev_q;
   assign idle_seen = arm & (idle_cnt_q == CNT_MAX);

   AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (arm && !both_high) |=> !idle_seen); // R5
   AST_STOP_NEEDS_SCL: assert property (@(posedge clk) disable iff (!rst_n)
      stop_seen |-> (scl && !sda_prev_q)); // R2
endmodule

// File: rtl/hj_join_fsm.sv
module hj_join_fsm
   import hj_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic disc_req,
   input  logic stop_seen,
   input  logic idle_seen,
   input  logic card_sda_hi,
   input  logic card_scl_hi,
   output logic arm,
   output logic connect_en,
   output logic ready
);
   join_state_e state_q, state_d;
   logic        conn_q, rdy_q;
   logic        safe_point;

   assign safe_point = (stop_seen | idle_seen) & card_sda_hi & card_scl_hi & ~disc_req;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_LOCKOUT: state_d = ST_WAIT;
         ST_WAIT:    if (safe_point) state_d = ST_JOINED;
         ST_JOINED:  if (disc_req)   state_d = ST_WAIT;
         default:    state_d = ST_LOCKOUT;
      endcase
      if (!pwr_good) state_d = ST_LOCKOUT;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_LOCKOUT;
         conn_q  <= 1'b0;
         rdy_q   <= 1'b0;
      end else begin
         state_q <= state_d;
         conn_q  <= (state_d == ST_JOINED);
         rdy_q   <= (state_d == ST_JOINED);
      end
   end

   assign arm        = (state_q == ST_WAIT);
   assign connect_en = conn_q;
   assign ready      = rdy_q;

   AST_LOCKOUT_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_good |=> !connect_en); // R8
   AST_JOIN_ON_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connect_en) |-> $past(stop_seen || idle_seen)); // R2
   AST_JOIN_CARD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(connect_en) |-> $past(card_sda_hi && card_scl_hi)); // R3
   AST_DISC_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      disc_req |=> !connect_en); // R6
endmodule

// File: rtl/i2c_hot_join_ctrl.sv
module i2c_hot_join_ctrl
   import hj_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned IDLE_CYCLES = 2500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_good,
   input  logic sda_in,
   input  logic scl_in,
   input  logic sda_out,
   input  logic scl_out,
   input  logic disc_req,
   output logic connect_en,
   output logic ready
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (IDLE_CYCLES < 2) begin : g_bad_idle
      $error("IDLE_CYCLES must be at least 2");
   end

   logic [NUM_LINES-1:0] line_raw, line_s;
   logic arm, stop_seen, idle_seen;

   assign line_raw[L_SDAI] = sda_in;
   assign line_raw[L_SCLI] = scl_in;
   assign line_raw[L_SDAO] = sda_out;
   assign line_raw[L_SCLO] = scl_out;

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_sync
      hj_bit_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
         .clk(clk), .rst_n(rst_n), .d_async(line_raw[i]), .q_sync(line_s[i])
      );
   end

   hj_live_watch #(.IDLE_CYCLES(IDLE_CYCLES)) u_watch (
      .clk(clk), .rst_n(rst_n), .arm(arm),
      .sda(line_s[L_SDAI]), .scl(line_s[L_SCLI]),
      .stop_seen(stop_seen), .idle_seen(idle_seen)
   );

   hj_join_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .disc_req(disc_req),
      .stop_seen(stop_seen), .idle_seen(idle_seen),
      .card_sda_hi(line_s[L_SDAO]), .card_scl_hi(line_s[L_SCLO]),
      .arm(arm), .connect_en(connect_en), .ready(ready)
   );

   AST_READY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      connect_en == ready); // R4
endmodule

// File: tb/i2c_hot_join_ctrl_bench.sv
module i2c_hot_join_ctrl_bench;
   localparam int unsigned IDLE = 12;
   localparam int NV = 14;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_good = 1'b0, sda_in = 1'b1, scl_in = 1'b1;
   logic sda_out = 1'b1, scl_out = 1'b1, disc_req = 1'b0;
   logic connect_en, ready;
   int   n_chk = 0, n_bad = 0;
   bit   done = 1'b0;

   always #10 clk = ~clk;

   i2c_hot_join_ctrl #(.SYNC_STAGES(2), .IDLE_CYCLES(IDLE)) u_i2c_hot_join_ctrl (
      .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
      .sda_in(sda_in), .scl_in(scl_in), .sda_out(sda_out), .scl_out(scl_out),
      .disc_req(disc_req), .connect_en(connect_en), .ready(ready)
   );

   // {pwr_good, sda_in, scl_in, sda_out, scl_out, disc_req, cycles[7:0], expected, req[3:0]}
   localparam logic [18:0] VEC [NV] = '{
      {6'b011110, 8'd30, 1'b0, 4'd1}, // R1 idle lines ignored in lockout
      {6'b101110, 8'd6,  1'b0, 4'd2}, // R2 live SDA low: no safe point
      {6'b111110, 8'd5,  1'b1, 4'd2}, // R2 STOP with card high joins
      {6'b111111, 8'd3,  1'b0, 4'd6}, // R6 disconnect request
      {6'b111110, 8'd5,  1'b0, 4'd7}, // R7 partial idle does not rejoin
      {6'b111110, 8'd12, 1'b1, 4'd5}, // R5 full idle rejoins
      {6'b011110, 8'd2,  1'b0, 4'd8}, // R8 power loss opens
      {6'b111010, 8'd20, 1'b0, 4'd3}, // R3 idle but card SDA low
      {6'b111110, 8'd4,  1'b1, 4'd3}, // R3 card releases: joins
      {6'b000000, 8'd3,  1'b0, 4'd8}, // R8 lockout again
      {6'b100110, 8'd20, 1'b0, 4'd2}, // R2 live bus held low
      {6'b110110, 8'd3,  1'b0, 4'd2}, // R2 SDA rises with SCL low
      {6'b111110, 8'd6,  1'b0, 4'd2}, // R2 SCL rise after SDA is not STOP
      {6'b111110, 8'd10, 1'b1, 4'd5}  // R5 idle completes
   };

   task automatic check(input string req, input logic exp);
      n_chk++;
      if (connect_en !== exp || ready !== exp) begin
         n_bad++;
         $display("FAIL %s: connect_en=%b ready=%b expected %b", req, connect_en, ready, exp);
      end
   endtask

   task automatic run(input int cyc);
      repeat (cyc) @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      run(3);
      check("R1 reset", 1'b0);
      rst_n = 1'b1;
      run(2);
      check("R1 lockout after reset", 1'b0);

      for (int i = 0; i < NV; i++) begin
         {pwr_good, sda_in, scl_in, sda_out, scl_out, disc_req} = VEC[i][18:13];
         run(int'(VEC[i][12:5]));
         check($sformatf("R%0d vector %0d", VEC[i][3:0], i), VEC[i][4]);
      end

      // R8: power loss while joined
      pwr_good = 1'b0;
      run(1);
      check("R8 drop while joined", 1'b0);
      // R1: a STOP during lockout is not remembered
      sda_in = 1'b0; run(4);
      sda_in = 1'b1; run(4);
      pwr_good = 1'b1;
      run(4);
      check("R1 lockout STOP ignored", 1'b0);

      // R5: SCL highs shorter than the idle window
      for (int k = 0; k < 8; k++) begin
         scl_in = 1'b0; run(2);
         scl_in = 1'b1; run(8);
         check("R5 short idle bursts", 1'b0);
      end
      run(18);
      check("R5 idle after bursts", 1'b1);

      // R6 pulse, then R3 STOP with card low, R7 stale STOP
      disc_req = 1'b1; run(1);
      disc_req = 1'b0;
      check("R6 disconnect pulse", 1'b0);
      sda_out = 1'b0;
      sda_in  = 1'b0; run(4);
      check("R3 START with card low", 1'b0);
      sda_in  = 1'b1; run(5);
      check("R3 STOP with card low", 1'b0);
      sda_out = 1'b1; run(3);
      check("R7 stale STOP ignored", 1'b0);
      run(10);
      check("R7 fresh idle joins", 1'b1);

      // R6 held request blocks join
      disc_req = 1'b1; run(30);
      check("R6 held disconnect", 1'b0);
      disc_req = 1'b0; run(2);
      check("R4 join after release", 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule